// File: doc/BRIEF.md
# Two-Wire Edge-Order Serial Transmitter

This block sends a data word over two wires that carry no clock and no fixed bit period. Every symbol is told apart from the others only by the order in which the two lines, called A and B, rise and fall. Both lines rest low. A word is handed over through a valid/ready handshake.

The block drops the zero bits above the highest set bit. It sends the remaining bits most significant first, then sends one end-of-word symbol. A word of all zeros still sends one 0 bit, so every word carries at least one data bit. On a full-width word the upper byte is meant for control use, but the block passes it through like any other data bits.

Each symbol takes four timed phases. Each phase lasts a parameter-set number of clock cycles:
- T1: from the A rise to the second edge.
- T2: the middle phase.
- T3: the third phase.
- T4: a gap with both lines low.

The default phase length is 25 microseconds, turned into cycles through a clock-rate parameter. Any phase set below one cycle is raised to one cycle.

The state machine has five states:
- `ST_IDLE`: ready high, both lines low.
- `ST_LEAD`: A high, B low.
- `ST_MID`: A high; B high unless the symbol is a 0 bit.
- `ST_TAIL`: A high and B low for a bit; A low and B high for the end-of-word symbol.
- `ST_GAP`: both lines low.

The transitions are:
- accept: `ST_IDLE` to `ST_LEAD`, on valid while ready.
- lead-done: `ST_LEAD` to `ST_MID`, when the T1 timer expires.
- mid-done: `ST_MID` to `ST_TAIL`, when the T2 timer expires.
- tail-done: `ST_TAIL` to `ST_GAP`, when the T3 timer expires.
- next-bit: `ST_GAP` to `ST_LEAD`, when the T4 timer expires and data bits remain.
- to-sync: `ST_GAP` to `ST_LEAD` with the end-of-word symbol selected, after bit 0.
- finish: `ST_GAP` to `ST_IDLE`, when the gap after the end-of-word symbol expires.

Top module: `edge_seq_tx`

## Requirements
- R1: After reset, `line_a` and `line_b` are 0 and `in_ready` is 1.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `line_a` rises on that same edge. `in_ready` stays 0 until the gap after the end-of-word symbol has run its full T4 cycles, and is 1 again in the cycle that follows.
- R3: For a non-zero word, the bits sent are the word's bits from the highest set bit down to bit 0, in that order. No bit above the highest set bit is sent.
- R4: A word equal to zero is sent as exactly one 0 bit followed by the end-of-word symbol.
- R5: A 0 bit holds `line_a`=1 for T1+T2+T3 cycles with `line_b`=0 throughout, then sets `line_a`=0.
- R6: A 1 bit sets `line_a`=1 for T1 cycles with `line_b`=0. It then sets `line_b`=1 for T2 cycles. It then sets `line_b`=0 for T3 cycles with `line_a` still 1, and then `line_a` falls. The B pulse therefore lies inside the A pulse.
- R7: The end-of-word symbol sets `line_a`=1 for T1 cycles. It then sets both lines to 1 for T2 cycles. It then sets `line_a`=0 with `line_b`=1 for T3 cycles, and then `line_b` falls. A leads B on both edges.
- R8: After every symbol, both lines are 0 for T4 cycles before the next symbol begins or `in_ready` returns.
- R9: Each phase lasts at least one cycle, even when its parameter is 0. So `line_b` never rises unless `line_a` was already 1 in the cycle before, and the two lines never change on the same clock edge.
- R10: While a word is in progress, `in_valid` and `in_data` have no effect on either line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_ready | output | 1 | High while the block can accept a word |
| in_data | input | DATA_W | Word to send |
| line_a | output | 1 | First signalling wire, idles low |
| line_b | output | 1 | Second signalling wire, idles low |

## Verification
The assertions check, on every cycle, the rules that do not depend on word content:
- `line_b` rises only after `line_a` has been high for at least one cycle.
- The two lines never change on the same edge.
- Both lines are low whenever `in_ready` is high.
- `in_ready` drops on the cycle after a word is accepted.

The phase lengths, the bits chosen by leading-zero suppression, the single 0 bit sent for a zero word, and the point at which `in_ready` returns depend on the word. Only the bench can show these. It sends every 8-bit value, compares each line against a waveform computed from the word cycle by cycle, and drives unrelated valid words during transmission.

// File: rtl/edge_seq_pkg.sv
package edge_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MID,
        ST_TAIL,
        ST_GAP
    } tx_state_t;

    typedef enum logic [1:0] {
        SYM_ZERO,
        SYM_ONE,
        SYM_SYNC
    } sym_t;

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/lead_one_finder.sv
module lead_one_finder #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     value,
    output logic [IDX_W-1:0] pos
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (value[i]) pos = IDX_W'(i);
        end
    end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt > CNT_W'(1)) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == CNT_W'(1));
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [W-1:0]     cap_word,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             step,
    output logic             next_bit,
    output logic             at_last
);
    logic [W-1:0]     word_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (capture) begin
            word_q <= cap_word;
            idx_q  <= cap_idx;
        end else if (step) begin
            idx_q  <= idx_q - 1'b1;
        end
    end

    assign next_bit = word_q[idx_q - 1'b1];
    assign at_last  = (idx_q == '0);
endmodule

// File: rtl/edge_seq_tx.sv
module edge_seq_tx
    import edge_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CLK_MHZ  = 50,
    parameter int PHASE_US = 25,
    parameter int T1 = CLK_MHZ * PHASE_US,
    parameter int T2 = CLK_MHZ * PHASE_US,
    parameter int T3 = CLK_MHZ * PHASE_US,
    parameter int T4 = CLK_MHZ * PHASE_US
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              line_a,
    output logic              line_b
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int D1 = at_least_one(T1);
    localparam int D2 = at_least_one(T2);
    localparam int D3 = at_least_one(T3);
    localparam int D4 = at_least_one(T4);
    localparam int DMAX12 = (D1 > D2) ? D1 : D2;
    localparam int DMAX34 = (D3 > D4) ? D3 : D4;
    localparam int DMAX = (DMAX12 > DMAX34) ? DMAX12 : DMAX34;
    localparam int CNT_W = $clog2(DMAX + 1) + 1;

    tx_state_t state_q, state_d;
    sym_t      sym_q, sym_d;

    logic [IDX_W-1:0] lead_pos;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             capture, step;
    logic             next_bit, at_last;

    lead_one_finder #(.W(DATA_W), .IDX_W(IDX_W)) u_lead (
        .value (in_data),
        .pos   (lead_pos)
    );

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    bit_shifter #(.W(DATA_W), .IDX_W(IDX_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .cap_word (in_data),
        .cap_idx  (lead_pos),
        .step     (step),
        .next_bit (next_bit),
        .at_last  (at_last)
    );

    // Next-state and control decode
    always_comb begin
        state_d  = state_q;
        sym_d    = sym_q;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(D1);
        capture  = 1'b0;
        step     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    capture  = 1'b1;
                    state_d  = ST_LEAD;
                    sym_d    = (in_data != '0) ? SYM_ONE : SYM_ZERO;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(D1);
                end
            end
            ST_LEAD: begin
                if (tmr_expired) begin
                    state_d  = ST_MID;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(D2);
                end
            end
            ST_MID: begin
                if (tmr_expired) begin
                    state_d  = ST_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(D3);
                end
            end
            ST_TAIL: begin
                if (tmr_expired) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(D4);
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    if (sym_q == SYM_SYNC) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_LEAD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(D1);
                        if (at_last) begin
                            sym_d = SYM_SYNC;
                        end else begin
                            step  = 1'b1;
                            sym_d = next_bit ? SYM_ONE : SYM_ZERO;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sym_q   <= SYM_ZERO;
        end else begin
            state_q <= state_d;
            sym_q   <= sym_d;
        end
    end

    // Output decode
    always_comb begin
        line_a   = 1'b0;
        line_b   = 1'b0;
        in_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_LEAD: line_a = 1'b1;
            ST_MID: begin
                line_a = 1'b1;
                line_b = (sym_q != SYM_ZERO);
            end
            ST_TAIL: begin
                line_a = (sym_q != SYM_SYNC);
                line_b = (sym_q == SYM_SYNC);
            end
            ST_GAP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/edge_seq_tx_chk.sv
module edge_seq_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic line_a,
    input logic line_b
);
    // R9: B may rise only once A has already been high for a cycle
    a_r9_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_b) |-> (line_a && $past(line_a)));

    // R9: the two lines never switch on the same edge
    a_r9_no_joint_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(($rose(line_a) || $fell(line_a)) && ($rose(line_b) || $fell(line_b))));

    // R1, R8: both lines rest low whenever a word can be taken
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!line_a && !line_b));

    // R2: ready drops right after an accepted word
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && line_a));

    // R5: A rises only while B is low
    a_r5_a_rise_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_a) |-> !line_b);
endmodule

bind edge_seq_tx edge_seq_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_a   (line_a),
    .line_b   (line_b)
);

// File: tb/sim_edge_seq_tx.sv
module sim_edge_seq_tx;
    localparam int DW = 8;
    localparam int P1 = 2;
    localparam int P2 = 3;
    localparam int P3 = 1;
    localparam int P4 = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, line_a, line_b;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit word_bad;
    bit inject;
    int inj_left;
    logic [DW-1:0] cur_word;

    always #5 clk = ~clk;

    edge_seq_tx #(.DATA_W(DW), .T1(P1), .T2(P2), .T3(P3), .T4(P4)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .line_a   (line_a),
        .line_b   (line_b)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: run did not end, actual cycle %0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Compare n cycles against expected line levels; in_ready must stay low.
    task automatic expect_phase(input int n, input bit ea, input bit eb, input string req);
        for (int k = 0; k < n; k++) begin
            if (!word_bad && (line_a !== ea || line_b !== eb || in_ready !== 1'b0)) begin
                word_bad = 1'b1;
                $display("FAIL %s word %0h: actual a=%b b=%b rdy=%b expected a=%b b=%b rdy=0",
                         req, cur_word, line_a, line_b, in_ready, ea, eb);
            end
            if (inject && inj_left > 0) begin
                in_valid = 1'b1;
                in_data  = ~cur_word;
                inj_left--;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_symbol(input int kind);
        if (kind == 0) begin
            expect_phase(P1 + P2 + P3, 1'b1, 1'b0, "R5 zero bit");
        end else if (kind == 1) begin
            expect_phase(P1, 1'b1, 1'b0, "R6 one bit lead");
            expect_phase(P2, 1'b1, 1'b1, "R6 one bit mid");
            expect_phase(P3, 1'b1, 1'b0, "R6 one bit tail");
        end else begin
            expect_phase(P1, 1'b1, 1'b0, "R7 sync lead");
            expect_phase(P2, 1'b1, 1'b1, "R7 sync mid");
            expect_phase(P3, 1'b0, 1'b1, "R7 sync tail");
        end
        expect_phase(P4, 1'b0, 1'b0, "R8 gap");
    endtask

    task automatic send_word(input logic [DW-1:0] v, input bit inj);
        int top;
        top = 0;
        for (int i = 0; i < DW; i++) if (v[i]) top = i;
        cur_word = v;
        word_bad = 1'b0;
        inject   = inj;
        inj_left = 4;
        in_valid = 1'b1;
        in_data  = v;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = top; i >= 0; i--) expect_symbol(v[i] ? 1 : 0);
        expect_symbol(2);
        tests++;
        if (word_bad) fails++;
        tests++;
        if (in_ready !== 1'b1 || line_a !== 1'b0 || line_b !== 1'b0) begin
            fails++;
            $display("FAIL R2 ready return word %0h: actual rdy=%b a=%b b=%b expected rdy=1 a=0 b=0",
                     v, in_ready, line_a, line_b);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (in_ready !== 1'b1 || line_a !== 1'b0 || line_b !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual rdy=%b a=%b b=%b expected rdy=1 a=0 b=0",
                     in_ready, line_a, line_b);
        end
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (in_ready !== 1'b1 || line_a !== 1'b0 || line_b !== 1'b0) begin
            fails++;
            $display("FAIL R1 after release: actual rdy=%b a=%b b=%b expected rdy=1 a=0 b=0",
                     in_ready, line_a, line_b);
        end
        // R4: zero word, R3: every non-zero word with leading-zero suppression
        for (int w = 0; w < (1 << DW); w++) begin
            send_word(DW'(w), 1'b0);
        end
        // R10: foreign valid words offered during transmission are ignored
        send_word(8'h01, 1'b1);
        send_word(8'h80, 1'b1);
        send_word(8'hA5, 1'b1);
        send_word(8'h00, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule